// File: doc/BRIEF.md
# Static memory bus cycle controller

This block turns internal memory requests into external bus cycles for a plain asynchronous static memory space. A request carries an address, a size, a direction, a line-transfer flag and up to one cache line of write data. The controller splits it into one or more beats. Each beat opens with a one-cycle start strobe, then runs a data phase in which the read strobe or the per-byte write enables are active. The controller drives address and data lines, and for reads it collects the returned device words into a line-wide result.

Two configuration inputs are sampled when a request is accepted. One sets the device width (16 or 32 bits). The other sets the wait mode. In one mode an extra cycle is inserted after the start strobe so that an external wait input can be sampled, and the data phase stretches while that input is held active. In the other mode the wait input plays no part. Line transfers always move 16 bytes from the line base with all lanes enabled, and the controller does not return to idle between their beats.

Top module: `sram_bus_ctrl`

## Requirements
- R1: With wait mode set to ignore (`cfg_wait_ignore`=1), every beat takes exactly two clocks: one start cycle and one data-phase cycle.
- R2: `ext_bs_n` is low for exactly one clock, the first clock of every beat, and never for two clocks in a row.
- R3: A read always fetches the full device width. On a 32-bit device `rd_data[31:0]` receives all 32 bits of `ext_din`, whatever the size. On a 16-bit device a byte or halfword read is one beat that fills `rd_data[15:0]` from `ext_din[15:0]`, and the rest of `rd_data` reads zero. The first beat drives the exact request address.
- R4: A write pulls low only the `ext_we_n` bits of the bytes being written. Lane k is `ext_dout[8k+7:8k]`, little-endian: a byte goes to lane addr[1:0] on a 32-bit device and to lane addr[0] on a 16-bit device, and a halfword goes to lanes {3,2} when addr[1]=1 and to lanes {1,0} otherwise. `req_size` encodes 0 = byte, 1 = halfword, 2 = longword.
- R5: On a 16-bit device a longword request becomes two halfword beats, at addr and addr+2. The low half goes first on reads and writes, and `ext_we_n[3:2]` stay high throughout.
- R6: With `req_burst`=1, 16 bytes move starting at the line base (addr with bits [3:0] cleared). This takes four beats with an address step of 4 on a 32-bit device, or eight beats with a step of 2 on a 16-bit device, back-to-back with `req_ready` low throughout. Beat k reads into, or writes from, bits [kW+W-1:kW] of the line data, where W is the device width.
- R7: A line transfer uses longword accesses whatever `req_size` holds: every beat enables all lanes of the device.
- R8: When idle, `ext_rdwr` is high (read level), `ext_rd_n` is high, `ext_we_n` is all ones and `ext_doe` is low.
- R9: With `cfg_wait_ignore`=0 a wait-evaluation cycle follows the start cycle. While `ext_wait_n` is sampled low there, one more clock is added each time, so an unwaited beat takes three clocks.
- R10: With `cfg_wait_ignore`=1, holding `ext_wait_n` low changes neither the beat length nor the data captured.
- R11: `ext_rd_n` is low only in the clocks of a read beat after its start cycle. `ext_rdwr` goes low only during write beats.
- R12: `done` is high for one clock, the clock after the last data phase. `req_ready` is high only when idle, and a request raised while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_ready | output | 1 | Controller idle, able to accept |
| req_addr | input | AW | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 halfword, 2 longword |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 16-byte line transfer |
| req_wdata | input | LINE_BYTES*8 | Write data; single accesses use the low bits |
| cfg_bus32 | input | 1 | 1 = 32-bit device, 0 = 16-bit device |
| cfg_wait_ignore | input | 1 | 1 = no wait cycle, wait input ignored |
| rd_data | output | LINE_BYTES*8 | Collected read data, valid with done |
| done | output | 1 | One-clock completion pulse |
| ext_addr | output | AW | External address |
| ext_bs_n | output | 1 | Bus-cycle start strobe, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_rdwr | output | 1 | Direction, high = read |
| ext_we_n | output | 4 | Per-byte write enables, active low |
| ext_dout | output | 32 | Write data to the device |
| ext_doe | output | 1 | Write data drive enable |
| ext_din | input | 32 | Read data from the device |
| ext_wait_n | input | 1 | External wait, active low |

## Verification
The bench starts line transfers from addresses in the middle of a line and with byte size. A design that did not align to the line base, or that kept the request size, would show wrong beat addresses or partial lane masks. The bench also runs halfword and longword traffic on a 16-bit device with junk on the upper data pins. A design that failed to split the access, or that took in the upper half, would return a wrong word or drive the upper enables. Wait tests hold the wait input low for several cycles in both modes, so any fixed wait penalty, or any wait honoured in the ignore mode, shows up as a wrong beat length. A request raised mid-burst checks that nothing extra is written once the burst ends.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_NOP  = 3'd2,
        ST_T2   = 3'd3,
        ST_DONE = 3'd4
    } state_e;

endpackage

// File: rtl/sbc_beat_plan.sv
// Works out the first beat address, the beat count and the size each beat uses.
module sbc_beat_plan
    import sbc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16,
    parameter int BW         = 3
) (
    input  logic [AW-1:0] addr,
    input  size_e         size,
    input  logic          burst,
    input  logic          bus32,
    output logic [AW-1:0] start_addr,
    output logic [BW-1:0] last_beat,
    output size_e         beat_size
);

    localparam logic [AW-1:0] LINE_MASK = AW'(LINE_BYTES - 1);
    localparam logic [BW-1:0] LAST_W32  = BW'(LINE_BYTES / 4 - 1);
    localparam logic [BW-1:0] LAST_W16  = BW'(LINE_BYTES / 2 - 1);

    always_comb begin
        if (burst) begin
            start_addr = addr & ~LINE_MASK;
            beat_size  = SZ_WORD;
            last_beat  = bus32 ? LAST_W32 : LAST_W16;
        end else begin
            start_addr = addr;
            beat_size  = size;
            last_beat  = (!bus32 && size == SZ_WORD) ? BW'(1) : '0;
        end
    end

endmodule

// File: rtl/sbc_lane_drive.sv
// Places write data on byte lanes and picks the write enables for one beat.
module sbc_lane_drive
    import sbc_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int BW         = 3,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic [1:0]           lane_addr,
    input  logic [BW-1:0]        beat_idx,
    input  size_e                beat_size,
    input  logic                 is_write,
    input  logic                 bus32,
    input  logic [LINE_BITS-1:0] wdata,
    output logic [3:0]           lane_we,
    output logic [31:0]          lane_dout
);

    always_comb begin
        lane_we   = '0;
        lane_dout = '0;
        if (is_write) begin
            if (bus32) begin
                case (beat_size)
                    SZ_BYTE: begin
                        lane_we   = 4'b0001 << lane_addr;
                        lane_dout = {4{wdata[7:0]}};
                    end
                    SZ_HALF: begin
                        lane_we   = lane_addr[1] ? 4'b1100 : 4'b0011;
                        lane_dout = {2{wdata[15:0]}};
                    end
                    default: begin
                        lane_we   = 4'b1111;
                        lane_dout = wdata[int'(beat_idx)*32 +: 32];
                    end
                endcase
            end else begin
                case (beat_size)
                    SZ_BYTE: begin
                        lane_we   = lane_addr[0] ? 4'b0010 : 4'b0001;
                        lane_dout = {16'h0000, {2{wdata[7:0]}}};
                    end
                    SZ_HALF: begin
                        lane_we   = 4'b0011;
                        lane_dout = {16'h0000, wdata[15:0]};
                    end
                    default: begin
                        lane_we   = 4'b0011;
                        lane_dout = {16'h0000, wdata[int'(beat_idx)*16 +: 16]};
                    end
                endcase
            end
        end
    end

    // R7: longword beats enable every lane of the device
    always_comb begin
        if (is_write && beat_size == SZ_WORD) begin
            assert_word_lanes_R7: assert (lane_we == (bus32 ? 4'b1111 : 4'b0011));
        end
    end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sbc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [AW-1:0]           req_addr,
    input  logic [1:0]              req_size,
    input  logic                    req_write,
    input  logic                    req_burst,
    input  logic [LINE_BYTES*8-1:0] req_wdata,
    input  logic                    cfg_bus32,
    input  logic                    cfg_wait_ignore,
    output logic [LINE_BYTES*8-1:0] rd_data,
    output logic                    done,
    output logic [AW-1:0]           ext_addr,
    output logic                    ext_bs_n,
    output logic                    ext_rd_n,
    output logic                    ext_rdwr,
    output logic [3:0]              ext_we_n,
    output logic [31:0]             ext_dout,
    output logic                    ext_doe,
    input  logic [31:0]             ext_din,
    input  logic                    ext_wait_n
);

    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int BW        = $clog2(LINE_BYTES / 2);
    localparam logic [AW-1:0] STEP_W32 = AW'(4);
    localparam logic [AW-1:0] STEP_W16 = AW'(2);

    typedef struct packed {
        state_e               st;
        logic [AW-1:0]        addr;
        logic [BW-1:0]        idx;
        logic [BW-1:0]        last;
        size_e                size;
        logic                 wr;
        logic                 bus32;
        logic                 wign;
        logic [LINE_BITS-1:0] wdata;
        logic [LINE_BITS-1:0] rdata;
    } ctl_t;

    ctl_t d, q;

    logic [AW-1:0] plan_start;
    logic [BW-1:0] plan_last;
    size_e         plan_size;
    logic [3:0]    lane_we;
    logic [31:0]   lane_dout;
    logic          data_phase;
    logic          active;

    sbc_beat_plan #(
        .AW         (AW),
        .LINE_BYTES (LINE_BYTES),
        .BW         (BW)
    ) u_plan (
        .addr       (req_addr),
        .size       (size_e'(req_size)),
        .burst      (req_burst),
        .bus32      (cfg_bus32),
        .start_addr (plan_start),
        .last_beat  (plan_last),
        .beat_size  (plan_size)
    );

    sbc_lane_drive #(
        .LINE_BYTES (LINE_BYTES),
        .BW         (BW)
    ) u_lane (
        .lane_addr  (q.addr[1:0]),
        .beat_idx   (q.idx),
        .beat_size  (q.size),
        .is_write   (q.wr),
        .bus32      (q.bus32),
        .wdata      (q.wdata),
        .lane_we    (lane_we),
        .lane_dout  (lane_dout)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_T1;
                    d.addr  = plan_start;
                    d.idx   = '0;
                    d.last  = plan_last;
                    d.size  = plan_size;
                    d.wr    = req_write;
                    d.bus32 = cfg_bus32;
                    d.wign  = cfg_wait_ignore;
                    d.wdata = req_wdata;
                    d.rdata = '0;
                end
            end
            ST_T1: begin
                d.st = q.wign ? ST_T2 : ST_NOP;
            end
            ST_NOP: begin
                if (ext_wait_n) begin
                    d.st = ST_T2;
                end
            end
            ST_T2: begin
                if (!q.wr) begin
                    if (q.bus32) begin
                        d.rdata[int'(q.idx)*32 +: 32] = ext_din;
                    end else begin
                        d.rdata[int'(q.idx)*16 +: 16] = ext_din[15:0];
                    end
                end
                if (q.idx == q.last) begin
                    d.st = ST_DONE;
                end else begin
                    d.st   = ST_T1;
                    d.idx  = q.idx + 1'b1;
                    d.addr = q.addr + (q.bus32 ? STEP_W32 : STEP_W16);
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_phase = (q.st == ST_NOP) || (q.st == ST_T2);
    assign active     = (q.st == ST_T1) || data_phase;

    assign req_ready = (q.st == ST_IDLE);
    assign done      = (q.st == ST_DONE);
    assign rd_data   = q.rdata;
    assign ext_addr  = q.addr;
    assign ext_bs_n  = (q.st != ST_T1);
    assign ext_rdwr  = !(active && q.wr);
    assign ext_rd_n  = !(data_phase && !q.wr);
    assign ext_we_n  = ~(lane_we & {4{data_phase}});
    assign ext_dout  = lane_dout;
    assign ext_doe   = active && q.wr;

    // R2: start strobe never lasts two clocks
    assert_bs_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_bs_n |=> ext_bs_n);

    // R1 and R10: in ignore mode the data phase directly follows the start cycle
    assert_nowait_two_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_bs_n && q.wign) |=> (q.st == ST_T2));

    // R8: idle levels on the external side
    assert_idle_levels_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ext_rdwr && ext_rd_n && (&ext_we_n) && !ext_doe));

    // R11: read strobe only in a read data phase
    assert_rd_data_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |-> (ext_bs_n && ext_rdwr));

    // R4: enables only during write data phases
    assert_we_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(&ext_we_n) |-> (!ext_rdwr && ext_bs_n && ext_rd_n));

    // R5: upper enables stay off on a 16-bit device
    assert_narrow_upper_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !q.bus32 |-> (&ext_we_n[3:2]));

    // R12: done is a single pulse followed by idle
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

endmodule

// File: tb/sim_sram_bus_ctrl.sv
module sim_sram_bus_ctrl;

    localparam int AW = 32;
    localparam int LB = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           req_valid;
    logic           req_ready;
    logic [AW-1:0]  req_addr;
    logic [1:0]     req_size;
    logic           req_write;
    logic           req_burst;
    logic [LB*8-1:0] req_wdata;
    logic           cfg_bus32;
    logic           cfg_wait_ignore;
    logic [LB*8-1:0] rd_data;
    logic           done;
    logic [AW-1:0]  ext_addr;
    logic           ext_bs_n;
    logic           ext_rd_n;
    logic           ext_rdwr;
    logic [3:0]     ext_we_n;
    logic [31:0]    ext_dout;
    logic           ext_doe;
    logic [31:0]    ext_din;
    logic           ext_wait_n;

    int tests = 0;
    int fails = 0;

    // monitor state
    bit          mon_en = 0;
    int          nbeat, rd_cyc, bs_double;
    bit          prev_bs_low;
    bit          ready_seen;
    logic [3:0]  mask_or;
    logic [31:0] beat_addr [16];
    logic [3:0]  beat_mask [16];
    logic [7:0]  wmem [256];
    int          wait_budget = 0;
    bit          hold_wait_low = 0;

    always #5 clk = ~clk;

    sram_bus_ctrl #(.AW(AW), .LINE_BYTES(LB)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_burst(req_burst), .req_wdata(req_wdata),
        .cfg_bus32(cfg_bus32), .cfg_wait_ignore(cfg_wait_ignore),
        .rd_data(rd_data), .done(done),
        .ext_addr(ext_addr), .ext_bs_n(ext_bs_n), .ext_rd_n(ext_rd_n),
        .ext_rdwr(ext_rdwr), .ext_we_n(ext_we_n), .ext_dout(ext_dout),
        .ext_doe(ext_doe), .ext_din(ext_din), .ext_wait_n(ext_wait_n)
    );

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a * 8'd13 + 8'h5B;
    endfunction

    // memory model: always answers with the full device width, junk on unused pins
    always_comb begin
        logic [7:0] b;
        if (cfg_bus32) begin
            b = ext_addr[7:0] & 8'hFC;
            ext_din = {pat(b + 8'd3), pat(b + 8'd2), pat(b + 8'd1), pat(b)};
        end else begin
            b = ext_addr[7:0] & 8'hFE;
            ext_din = {16'hDEAD, pat(b + 8'd1), pat(b)};
        end
    end

    assign ext_wait_n = !(hold_wait_low || wait_budget > 0);

    always @(negedge clk) begin
        if (mon_en) begin
            if (!ext_bs_n) begin
                if (nbeat < 16) beat_addr[nbeat] = ext_addr;
                nbeat++;
            end
            if (!ext_bs_n && prev_bs_low) bs_double++;
            prev_bs_low = !ext_bs_n;
            if (req_ready) ready_seen = 1;
            if (!ext_rd_n) begin
                rd_cyc++;
                if (wait_budget > 0) wait_budget--;
            end
            if (!(&ext_we_n)) begin
                logic [7:0] al;
                al = cfg_bus32 ? (ext_addr[7:0] & 8'hFC) : (ext_addr[7:0] & 8'hFE);
                mask_or = mask_or | ~ext_we_n;
                if (nbeat > 0 && nbeat <= 16) beat_mask[nbeat-1] = ~ext_we_n;
                for (int l = 0; l < 4; l++) begin
                    if (!ext_we_n[l]) wmem[al + 8'(l)] = ext_dout[8*l +: 8];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_wmem();
        for (int i = 0; i < 256; i++) wmem[i] = 8'h00;
    endtask

    task automatic run(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                       input bit bu, input bit b32, input bit wign,
                       input logic [127:0] wd, output int cyc);
        @(negedge clk);
        req_addr = a; req_size = sz; req_write = wr; req_burst = bu;
        cfg_bus32 = b32; cfg_wait_ignore = wign; req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk);
        nbeat = 0; rd_cyc = 0; bs_double = 0; prev_bs_low = 0;
        ready_seen = 0; mask_or = '0;
        for (int i = 0; i < 16; i++) begin beat_addr[i] = '0; beat_mask[i] = '0; end
        mon_en = 1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        mon_en = 0;
        if (cyc >= 200) chk(0, "R12", "done never seen", 128'(cyc), 128'd0);
    endtask

    task automatic check_done_falls(input string tag);
        @(negedge clk);
        chk(!done && req_ready, "R12", {tag, " done not one clock"},
            128'({done, req_ready}), 128'b01);
    endtask

    function automatic logic [127:0] line_pat(input logic [7:0] base);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[8*i +: 8] = pat(base + 8'(i));
        return v;
    endfunction

    function automatic logic [127:0] line_wmem(input logic [7:0] base);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[8*i +: 8] = wmem[base + 8'(i)];
        return v;
    endfunction

    task automatic t_reset();
        chk(req_ready && ext_bs_n && ext_rdwr && ext_rd_n && (&ext_we_n) && !ext_doe && !done,
            "R8", "reset levels",
            128'({req_ready, ext_bs_n, ext_rdwr, ext_rd_n, ext_we_n, ext_doe, done}),
            128'b1111_1111_00);
    endtask

    task automatic t_read32_byte();
        int c;
        run(32'h105, 2'd0, 0, 0, 1, 1, '0, c);
        chk(c == 2, "R1", "no-wait read length", 128'(c), 128'd2);
        chk(nbeat == 1 && beat_addr[0] == 32'h105, "R3", "exact address on bus",
            128'(beat_addr[0]), 128'h105);
        chk(rd_data[31:0] == {pat(8'h07), pat(8'h06), pat(8'h05), pat(8'h04)}, "R3",
            "full 32-bit read", 128'(rd_data[31:0]),
            128'({pat(8'h07), pat(8'h06), pat(8'h05), pat(8'h04)}));
        chk(rd_cyc == 1 && bs_double == 0, "R11", "read strobe cycles", 128'(rd_cyc), 128'd1);
        check_done_falls("read32");
    endtask

    task automatic t_write32_byte_half();
        int c;
        clear_wmem();
        run(32'h102, 2'd0, 1, 0, 1, 1, 128'hA5, c);
        chk(mask_or == 4'b0100, "R4", "byte lane mask", 128'(mask_or), 128'b0100);
        chk(wmem[8'h02] == 8'hA5 && wmem[8'h03] == 8'h00 && wmem[8'h01] == 8'h00, "R4",
            "byte write value", 128'(wmem[8'h02]), 128'hA5);
        run(32'h106, 2'd1, 1, 0, 1, 1, 128'hBEEF, c);
        chk(mask_or == 4'b1100, "R4", "half lane mask", 128'(mask_or), 128'b1100);
        chk({wmem[8'h07], wmem[8'h06]} == 16'hBEEF && wmem[8'h05] == 8'h00, "R4",
            "half write value", 128'({wmem[8'h07], wmem[8'h06]}), 128'hBEEF);
        chk(c == 2, "R1", "no-wait write length", 128'(c), 128'd2);
    endtask

    task automatic t_narrow_word();
        int c;
        run(32'h108, 2'd2, 0, 0, 0, 1, '0, c);
        chk(nbeat == 2 && beat_addr[0] == 32'h108 && beat_addr[1] == 32'h10A, "R5",
            "split read addresses", 128'({beat_addr[0], beat_addr[1]}), 128'h108_0000010A);
        chk(rd_data[31:0] == {pat(8'h0B), pat(8'h0A), pat(8'h09), pat(8'h08)} &&
            rd_data[127:32] == '0, "R5", "split read data", rd_data,
            128'({pat(8'h0B), pat(8'h0A), pat(8'h09), pat(8'h08)}));
        chk(c == 4, "R2", "two beats of two clocks", 128'(c), 128'd4);
        clear_wmem();
        run(32'h10C, 2'd2, 1, 0, 0, 1, 128'h11223344, c);
        chk(mask_or == 4'b0011, "R5", "narrow enables only low lanes", 128'(mask_or), 128'b0011);
        chk({wmem[8'h0F], wmem[8'h0E], wmem[8'h0D], wmem[8'h0C]} == 32'h11223344, "R5",
            "split write data",
            128'({wmem[8'h0F], wmem[8'h0E], wmem[8'h0D], wmem[8'h0C]}), 128'h11223344);
    endtask

    task automatic t_narrow_byte_read();
        int c;
        run(32'h111, 2'd0, 0, 0, 0, 1, '0, c);
        chk(nbeat == 1 && c == 2, "R3", "narrow byte read single beat", 128'(nbeat), 128'd1);
        chk(rd_data == 128'({pat(8'h11), pat(8'h10)}), "R3", "narrow full-width read",
            rd_data, 128'({pat(8'h11), pat(8'h10)}));
    endtask

    task automatic t_burst_read32();
        int c;
        run(32'h126, 2'd0, 0, 1, 1, 1, '0, c);
        chk(nbeat == 4 && beat_addr[0] == 32'h120 && beat_addr[1] == 32'h124 &&
            beat_addr[2] == 32'h128 && beat_addr[3] == 32'h12C, "R6", "line beat addresses",
            128'(nbeat), 128'd4);
        chk(c == 8 && !ready_seen, "R6", "back-to-back without release", 128'(c), 128'd8);
        chk(rd_data == line_pat(8'h20), "R6", "line read data", rd_data, line_pat(8'h20));
    endtask

    task automatic t_burst_write16();
        int c;
        bit ok;
        logic [127:0] ln;
        ln = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
        clear_wmem();
        run(32'h134, 2'd1, 1, 1, 0, 1, ln, c);
        ok = (nbeat == 8);
        for (int i = 0; i < 8; i++) begin
            if (beat_addr[i] != 32'h130 + 32'(2 * i)) ok = 0;
        end
        chk(ok && c == 16 && !ready_seen, "R6", "narrow line beats", 128'(nbeat), 128'd8);
        ok = 1;
        for (int i = 0; i < 8; i++) if (beat_mask[i] != 4'b0011) ok = 0;
        chk(ok, "R7", "narrow line uses full width", 128'(beat_mask[0]), 128'b0011);
        chk(line_wmem(8'h30) == ln, "R6", "narrow line write data", line_wmem(8'h30), ln);
    endtask

    task automatic t_burst_write32();
        int c;
        bit ok;
        logic [127:0] ln;
        ln = 128'hCAFEF00D_DEADBEEF_01234567_89ABCDEF;
        clear_wmem();
        run(32'h141, 2'd0, 1, 1, 1, 1, ln, c);
        ok = (nbeat == 4);
        for (int i = 0; i < 4; i++) if (beat_mask[i] != 4'b1111) ok = 0;
        chk(ok, "R7", "byte-size line forced to longword", 128'(beat_mask[0]), 128'hF);
        chk(line_wmem(8'h40) == ln, "R6", "wide line write data", line_wmem(8'h40), ln);
    endtask

    task automatic t_wait_mode();
        int c;
        wait_budget = 0;
        run(32'h150, 2'd2, 0, 0, 1, 0, '0, c);
        chk(c == 3 && rd_cyc == 2, "R9", "wait cycle inserted", 128'(c), 128'd3);
        wait_budget = 3;
        run(32'h154, 2'd2, 0, 0, 1, 0, '0, c);
        chk(c == 5, "R9", "wait extends data phase", 128'(c), 128'd5);
        chk(rd_data[31:0] == {pat(8'h57), pat(8'h56), pat(8'h55), pat(8'h54)}, "R9",
            "waited read data", 128'(rd_data[31:0]),
            128'({pat(8'h57), pat(8'h56), pat(8'h55), pat(8'h54)}));
        wait_budget = 0;
        hold_wait_low = 1;
        run(32'h158, 2'd2, 0, 0, 1, 1, '0, c);
        hold_wait_low = 0;
        chk(c == 2, "R10", "wait ignored length", 128'(c), 128'd2);
        chk(rd_data[31:0] == {pat(8'h5B), pat(8'h5A), pat(8'h59), pat(8'h58)}, "R10",
            "wait ignored data", 128'(rd_data[31:0]),
            128'({pat(8'h5B), pat(8'h5A), pat(8'h59), pat(8'h58)}));
    endtask

    task automatic t_busy_drop();
        int c;
        clear_wmem();
        @(negedge clk);
        req_addr = 32'h160; req_size = 2'd2; req_write = 0; req_burst = 1;
        cfg_bus32 = 1; cfg_wait_ignore = 1; req_wdata = '0;
        req_valid = 1'b1;
        @(posedge clk);
        nbeat = 0; mask_or = '0; prev_bs_low = 0; bs_double = 0;
        mon_en = 1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        req_addr = 32'h1F0; req_write = 1; req_burst = 0; req_size = 2'd2;
        req_wdata = 128'h77777777; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        c = 0;
        while (!done && c < 200) begin
            @(negedge clk);
            c++;
        end
        check_done_falls("busy");
        for (int i = 0; i < 3; i++) @(negedge clk);
        mon_en = 0;
        chk(nbeat == 4 && mask_or == 4'b0000 && wmem[8'hF0] == 8'h00, "R12",
            "request while busy dropped", 128'({nbeat, mask_or}), 128'h40);
        chk(rd_data == line_pat(8'h60), "R12", "line intact despite drop", rd_data,
            line_pat(8'h60));
    endtask

    initial begin
        #2_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_addr = '0; req_size = '0; req_write = 0;
        req_burst = 0; req_wdata = '0; cfg_bus32 = 1; cfg_wait_ignore = 1;
        clear_wmem();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read32_byte();
        t_write32_byte_half();
        t_narrow_word();
        t_narrow_byte_read();
        t_burst_read32();
        t_burst_write16();
        t_burst_write32();
        t_wait_mode();
        t_busy_drop();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule